// File: doc/BRIEF.md
# Timer Output Compare Unit

The block pairs a free-running counter with one compare channel. A two-bit phase generator divides the internal clock into four sub-states per timer cycle, T00 to T11. The counter advances once per timer cycle. A byte-wide register bus writes a compare value in two halves, sets an output level and an interrupt enable, reads a status byte, and reads the live counter.

The counter is checked against the compare value only in sub-state T01. A hit is held until the T11 of the same timer cycle. At the end of that T11 the compare flag goes high and the output pin takes the programmed level. An interrupt request is raised while the flag is set and interrupts are enabled. Writing the upper compare half stops all compares until the lower half is written. The flag is cleared by a two-step sequence: a status read taken while the flag is set arms the clear, and the next lower-half write performs it.

Top module: `ocmp_unit`

## Requirements
- R1: Reset sets the phase to T00, the counter to all ones minus three (0xFFFC at the default width), and the compare value to all ones with compares enabled. Reset clears the flag, the pin and the interrupt request.
- R2: The counter holds in T00, T01 and T10 and increments by one at the end of T11, wrapping modulo 2^(2*DATA_W). The next clock edge after reset release moves the phase to T01.
- R3: A compare hit is taken only in T01. The flag rises at the clock edge that ends the T11 of the same timer cycle, which is the edge where the counter leaves the matching value. A compare value that becomes effective after the T01 of the current cycle waits for the next occurrence of that value.
- R4: Writing the upper compare half blocks every compare until the lower half is written. Writing the lower half enables compares again.
- R5: A lower-half write clears the flag only if a status read that found the flag set was taken after the flag last rose. A lower-half write without such a read leaves the flag set.
- R6: A new flag-setting event cancels an armed clear. If the flag is set in the same cycle as a clearing write, the flag stays set.
- R7: When the flag is set, the pin takes the pin-level control bit. The interrupt request equals the flag ANDed with the interrupt-enable bit.
- R8: Register map by bus_addr:
  - 0: control. Bit 0 is the pin level, bit 1 is the interrupt enable; both are readable.
  - 1: status. The flag is in the most significant bit; all other bits read zero.
  - 2: upper compare half.
  - 3: lower compare half.
  - 4: upper counter half, read only.
  - 5: lower counter half, read only.
  - bus_rdata is combinational from bus_addr.
- R9: A status read taken while the flag is clear does not arm a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for the status read) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| cmp_pin | output | 1 | Compare output pin |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The case that needs care is a lower-half write that tries to clear the flag in the same cycle that a new match sets it again. The bench arms a clear and lets the compare value recur after a counter wrap; the short counter of the bench configuration makes the wrap reach quickly. It then times the lower-half write to land on exactly the edge that ends T11, and requires the interrupt to stay high. The bench also commits compare values in each of the four sub-states. It expects an immediate hit only when the value becomes effective by T01, and otherwise one full counter wrap later.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [1:0] {
        PH_T00 = 2'd0,
        PH_T01 = 2'd1,
        PH_T10 = 2'd2,
        PH_T11 = 2'd3
    } tphase_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CMPH = 3'd2;
    localparam logic [2:0] A_CMPL = 3'd3;
    localparam logic [2:0] A_CNTH = 3'd4;
    localparam logic [2:0] A_CNTL = 3'd5;

    typedef struct packed {
        logic irq_en;
        logic pin_lvl;
    } ctrl_t;

    typedef struct packed {
        logic ctrl_wr;
        logic cmph_wr;
        logic cmpl_wr;
        logic stat_rd;
    } dec_t;

    function automatic dec_t bus_decode(input logic wr, input logic rd, input logic [2:0] addr);
        dec_t d;
        d.ctrl_wr = wr && (addr == A_CTRL);
        d.cmph_wr = wr && (addr == A_CMPH);
        d.cmpl_wr = wr && (addr == A_CMPL);
        d.stat_rd = rd && (addr == A_STAT);
        return d;
    endfunction

    function automatic tphase_e phase_next(input tphase_e p);
        return tphase_e'(p + 2'd1);
    endfunction

endpackage

// File: rtl/ocmp_timebase.sv
module ocmp_timebase
    import ocmp_pkg::*;
#(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] CNT_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    output tphase_e          phase,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_T00;
            cnt   <= CNT_RST;
        end else begin
            phase <= phase_next(phase);
            if (phase == PH_T11) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocmp_cmpreg.sv
module ocmp_cmpreg #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  ocr,
    output logic              cmp_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ocr    <= '1;
            cmp_en <= 1'b1;
        end else if (hi_wr) begin
            ocr[CNT_W-1:DATA_W] <= wdata;
            cmp_en              <= 1'b0;
        end else if (lo_wr) begin
            ocr[DATA_W-1:0] <= wdata;
            cmp_en          <= 1'b1;
        end
    end

endmodule

// File: rtl/ocmp_flagctl.sv
module ocmp_flagctl
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tphase_e          phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ocr,
    input  logic             cmp_en,
    input  logic             stat_rd,
    input  logic             lo_wr,
    input  logic             pin_lvl,
    input  logic             irq_en,
    output logic             pend,
    output logic             flag,
    output logic             pin,
    output logic             irq
);

    logic hit;
    logic set_ev;
    logic armed;

    assign hit    = (phase == PH_T01) && cmp_en && (cnt == ocr);
    assign set_ev = pend && (phase == PH_T11);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            flag  <= 1'b0;
            armed <= 1'b0;
            pin   <= 1'b0;
        end else begin
            if (hit) begin
                pend <= 1'b1;
            end else if (phase == PH_T11) begin
                pend <= 1'b0;
            end

            if (set_ev) begin
                flag  <= 1'b1;
                pin   <= pin_lvl;
                armed <= 1'b0;
            end else begin
                if (stat_rd && flag) begin
                    armed <= 1'b1;
                end
                if (lo_wr && armed) begin
                    flag  <= 1'b0;
                    armed <= 1'b0;
                end
            end
        end
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmp_pin,
    output logic              cmp_irq
);

    localparam int              CNT_W   = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_RST = ~CNT_W'(3);

    tphase_e          phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ocr;
    logic             cmp_en;
    logic             pend;
    logic             flag;
    logic             lo_wr;
    ctrl_t            ctrl;
    dec_t             dec;

    assign dec   = bus_decode(bus_wr, bus_rd, bus_addr);
    assign lo_wr = dec.cmpl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (dec.ctrl_wr) begin
            ctrl <= ctrl_t'(bus_wdata[1:0]);
        end
    end

    ocmp_timebase #(
        .CNT_W  (CNT_W),
        .CNT_RST(CNT_RST)
    ) tb_i (
        .clk  (clk),
        .rst  (rst),
        .phase(phase),
        .cnt  (cnt)
    );

    ocmp_cmpreg #(
        .DATA_W(DATA_W)
    ) creg_i (
        .clk   (clk),
        .rst   (rst),
        .hi_wr (dec.cmph_wr),
        .lo_wr (lo_wr),
        .wdata (bus_wdata),
        .ocr   (ocr),
        .cmp_en(cmp_en)
    );

    ocmp_flagctl #(
        .CNT_W(CNT_W)
    ) fctl_i (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .cnt    (cnt),
        .ocr    (ocr),
        .cmp_en (cmp_en),
        .stat_rd(dec.stat_rd),
        .lo_wr  (lo_wr),
        .pin_lvl(ctrl.pin_lvl),
        .irq_en (ctrl.irq_en),
        .pend   (pend),
        .flag   (flag),
        .pin    (cmp_pin),
        .irq    (cmp_irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[1:0]        = ctrl;
            A_STAT:  bus_rdata[DATA_W-1]   = flag;
            A_CMPH:  bus_rdata             = ocr[CNT_W-1:DATA_W];
            A_CMPL:  bus_rdata             = ocr[DATA_W-1:0];
            A_CNTH:  bus_rdata             = cnt[CNT_W-1:DATA_W];
            A_CNTL:  bus_rdata             = cnt[DATA_W-1:0];
            default: bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       phase,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic             cmp_en,
    input logic             flag,
    input logic             lo_wr,
    input logic             irq
);

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(cnt)); // R2

    AST_HIT_IN_T01: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> ($past(phase) == 2'd1)); // R3

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(cmp_en)); // R4

    AST_FLAG_AT_T00: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (phase == 2'd0)); // R3

    AST_CLEAR_BY_LO_WR: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(lo_wr)); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R7

endmodule

bind ocmp_unit ocmp_unit_chk #(
    .DATA_W(DATA_W)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .cnt   (cnt),
    .pend  (pend),
    .cmp_en(cmp_en),
    .flag  (flag),
    .lo_wr (lo_wr),
    .irq   (cmp_irq)
);

// File: tb/ocmp_unit_tb_top.sv
`timescale 1ns/1ps
module ocmp_unit_tb_top;
    import ocmp_pkg::*;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cmp_pin;
    logic          cmp_irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    ocmp_unit #(.DATA_W(DW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cmp_pin  (cmp_pin),
        .cmp_irq  (cmp_irq)
    );

    function automatic logic [7:0] cnt_at(input int e);
        return 8'(32'hFC + e / 4);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Program compare = counter-at-commit + off, committing the low half in phase cp.
    task automatic set_cmp(input int off, input int cp, input logic ie, input logic lvl,
                           output int exp_e, output logic [7:0] v);
        logic [DW-1:0] d;
        int c;
        rd(A_STAT, d);
        wr(A_CTRL, {2'b00, ie, lvl});
        while (((cyc + 2) % 4) != cp) @(negedge clk);
        c = cyc + 2;
        v = cnt_at(c) + 8'(off);
        wr(A_CMPH, v[7:4]);
        wr(A_CMPL, v[3:0]);
        if (off == 0) exp_e = (cp <= 1) ? 4 * (c / 4 + 1) : 4 * (c / 4 + 1) + 1024;
        else          exp_e = 4 * (c / 4 + off + 1);
    endtask

    task automatic wait_irq(input int exp_e);
        while (!cmp_irq && cyc < exp_e + 8) @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] d;
        logic [7:0] v;
        int e;
        int c0;

        // Reset state, sampled while reset is held (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_addr = A_CNTH; #1 chk("R1 cnt hi", int'(bus_rdata), 15);
        bus_addr = A_CNTL; #1 chk("R1 cnt lo", int'(bus_rdata), 12);
        bus_addr = A_CMPH; #1 chk("R1 cmp hi", int'(bus_rdata), 15);
        bus_addr = A_CMPL; #1 chk("R1 cmp lo", int'(bus_rdata), 15);
        bus_addr = A_STAT; #1 chk("R1 status", int'(bus_rdata), 0);
        chk("R1 irq", int'(cmp_irq), 0);
        chk("R1 pin", int'(cmp_pin), 0);
        @(negedge clk);
        rst = 1'b0;

        // Counter steps every four clocks and wraps (R2)
        for (int k = 0; k < 24; k++) begin
            c0 = cyc;
            if (k % 3 == 0) begin
                rd(A_CNTH, d);
                chk("R2 cnt hi", int'(d), int'(cnt_at(c0) >> 4));
            end else begin
                rd(A_CNTL, d);
                chk("R2 cnt lo", int'(d), int'(cnt_at(c0) & 8'h0F));
            end
        end

        // Control readback (R8)
        wr(A_CTRL, 4'b0011);
        rd(A_CTRL, d);
        chk("R8 ctrl readback", int'(d), 3);

        // Sweep commit phase and offset (R3, R5, R7, R8)
        for (int cp = 0; cp < 4; cp++) begin
            for (int off = 0; off < 3; off++) begin
                logic lvl;
                lvl = logic'((cp + off + 1) % 2);
                set_cmp(off, cp, 1'b1, lvl, e, v);
                chk("R5 flag cleared by read then low write", int'(cmp_irq), 0);
                rd(A_CMPH, d);
                chk("R8 cmp hi readback", int'(d), int'(v[7:4]));
                wait_irq(e);
                chk("R3 flag edge", cyc, e);
                chk("R7 pin level", int'(cmp_pin), int'(lvl));
                rd(A_STAT, d);
                chk("R8 status msb", int'(d), 8);
            end
        end

        // Interrupt enable off: flag set, request low (R7)
        set_cmp(2, 1, 1'b0, 1'b1, e, v);
        wait_until(e + 1);
        chk("R7 irq masked", int'(cmp_irq), 0);
        rd(A_STAT, d);
        chk("R7 flag set while masked", int'(d), 8);
        wr(A_CTRL, 4'b0011);
        chk("R7 irq after enable", int'(cmp_irq), 1);

        // Upper-half write inhibits compares (R4)
        set_cmp(3, 0, 1'b1, 1'b0, e, v);
        wr(A_CMPH, v[7:4]);
        wait_until(e + 4);
        chk("R4 inhibited no flag", int'(cmp_irq), 0);
        rd(A_STAT, d);
        chk("R4 inhibited status", int'(d), 0);
        set_cmp(2, 2, 1'b1, 1'b1, e, v);
        wait_irq(e);
        chk("R4 re-enabled by low write", cyc, e);

        // Read while flag clear does not arm (R9)
        set_cmp(2, 3, 1'b1, 1'b1, e, v);
        rd(A_STAT, d);
        wait_irq(e);
        chk("R9 flag set", int'(cmp_irq), 1);
        wr(A_CMPL, v[3:0]);
        chk("R9 unarmed low write keeps flag", int'(cmp_irq), 1);

        // New set disarms (R6)
        rd(A_STAT, d);
        wait_until(e + 1024 + 1);
        wr(A_CMPL, v[3:0]);
        chk("R6 disarmed by new set", int'(cmp_irq), 1);

        // Set and clear in the same cycle: set wins (R6)
        rd(A_STAT, d);
        wait_until(e + 2048 - 1);
        wr(A_CMPL, v[3:0]);
        chk("R6 collision cyc", cyc, e + 2048);
        chk("R6 set wins over clear", int'(cmp_irq), 1);

        // Proper clear sequence (R5)
        rd(A_STAT, d);
        wr(A_CMPL, v[3:0]);
        chk("R5 read then low write clears", int'(cmp_irq), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule